// File: doc/BRIEF.md
# Multi-Mode Built-In Test Register

This block is an n-bit register that doubles as on-chip test hardware. A 2-bit mode code selects its role. It can be a plain parallel D register in functional operation. It can be a serial scan chain for loading and unloading state. It can be an autonomous linear-feedback pattern source that drives stimulus into a circuit under test. It can also be a multiple-input signature register that folds the circuit's n parallel responses into a compact signature.

All four roles share one set of flip-flops. In the two linear modes they share one internal-XOR (modular) feedback network built from a tap vector parameter. The parallel output always shows the register contents. The top stage also serves as the scan output. An outside controller chooses the modes, seeds the register and compares signatures.

Top module: `bilbo_reg`

## Requirements
- R1: A synchronous active-high `rst` sets all stages of `q` to zero on the next rising clock edge.
- R2: With `mode` = 2'b10 (functional), `q` takes the value of `d` on each rising edge.
- R3: With `mode` = 2'b00 (shift), on each edge `q[0]` takes `scan_in` and `q[i]` takes the old `q[i-1]`; `d` has no effect.
- R4: `scan_out` always equals `q[WIDTH-1]`.
- R5: With `mode` = 2'b01 (generate), the register makes one modular LFSR step per edge and `d` has no effect. The step uses feedback f = old `q[WIDTH-1]`: new `q[0]` = f, and new `q[i]` = old `q[i-1]` XOR (f AND `TAPS[i]`). With the default taps (x^8+x^4+x^3+x^2+1, `TAPS` = 8'h1C), a nonzero seed returns to itself after exactly 255 steps and not sooner.
- R6: In generate mode, an all-zero register stays all-zero, and a nonzero register never becomes all-zero.
- R7: With `mode` = 2'b11 (compact), the next state is the R5 step of the old state XORed bit by bit with `d`.
- R8: Starting from zero, the compact-mode signature after any input sequence equals the XOR of the signatures obtained by feeding each input lane alone.
- R9: Shifting `WIDTH` zeros through in shift mode clears every stage, whatever the starting contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | Mode code: 00 shift, 01 generate, 10 functional, 11 compact |
| d | input | WIDTH | Parallel data / response inputs |
| scan_in | input | 1 | Serial input into stage 0 |
| q | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial output, top stage |

## Verification
The checker checks the following on every cycle: the clear on reset, parallel capture in functional mode, the shift relation in shift mode, that the scan output tracks the top stage, and that generate mode never falls into or leaves the zero state. The bench's scenarios are needed to show the arithmetic of the feedback. They cover the full period of the default polynomial, exhaustive single-step compact-mode transitions, superposition of the input lanes in the signature, and clearing the register by shifting zeros.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_GEN   = 2'b01,
    MODE_FUNC  = 2'b10,
    MODE_COMP  = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_feedback.sv
// Companion-matrix step of a modular (internal XOR) LFSR.
module bilbo_feedback #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h1C
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] stepped
);
  logic fb;
  assign fb = cur[WIDTH-1];
  assign stepped[0] = fb;
  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    if (TAPS[i]) begin : g_tap
      assign stepped[i] = cur[i-1] ^ fb;
    end else begin : g_plain
      assign stepped[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/bilbo_next.sv
// Next-state selection for the four modes.
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bilbo_mode_e      mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] stepped,
  input  logic [WIDTH-1:0] d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] shifted;
  assign shifted = {cur[WIDTH-2:0], scan_in};

  always_comb begin
    unique case (mode)
      MODE_SHIFT: nxt = shifted;
      MODE_GEN:   nxt = stepped;
      MODE_FUNC:  nxt = d;
      MODE_COMP:  nxt = stepped ^ d;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'h1C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q,
  output logic             scan_out
);
  logic [WIDTH-1:0] state_r;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nxt;
  bilbo_mode_e      mode_e;

  assign mode_e = bilbo_mode_e'(mode);

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .cur     (state_r),
    .stepped (stepped)
  );

  bilbo_next #(.WIDTH(WIDTH)) u_next (
    .mode    (mode_e),
    .cur     (state_r),
    .stepped (stepped),
    .d       (d),
    .scan_in (scan_in),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state_r <= '0;
    else     state_r <= nxt;
  end

  assign q        = state_r;
  assign scan_out = state_r[WIDTH-1];
endmodule

// File: rtl/bilbo_chk.sv
module bilbo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] d,
  input logic             scan_in,
  input logic [WIDTH-1:0] q,
  input logic             scan_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R2
  func_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (q == $past(d)));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == {$past(q[WIDTH-2:0]), $past(scan_in)}));

  // R4
  always_comb scan_top_chk: assert (scan_out == q[WIDTH-1]);

  // R6
  gen_zero_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && q == '0) |=> (q == '0));

  // R6
  gen_no_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && q != '0) |=> (q != '0));
endmodule

bind bilbo_reg bilbo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .d(d),
  .scan_in(scan_in), .q(q), .scan_out(scan_out)
);

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;
  localparam int W = 8;
  localparam logic [W-1:0] TP = 8'h1C;

  logic clk = 0;
  logic rst = 1;
  logic [1:0] mode = 2'b10;
  logic [W-1:0] d = '0;
  logic scan_in = 0;
  logic [W-1:0] q;
  logic scan_out;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAPS(TP)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .d(d),
    .scan_in(scan_in), .q(q), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] step(input logic [W-1:0] x);
    logic [W-1:0] r;
    r[0] = x[W-1];
    for (int i = 1; i < W; i++) r[i] = x[i-1] ^ (x[W-1] & TP[i]);
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] v);
    mode = 2'b10; d = v; tick();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] m, seed, sig, acc;
    logic [W-1:0] lane [W];
    logic [W-1:0] seq [20];
    int period;
    d = 8'hA5;
    tick(); tick();
    check("R1", q, '0);
    check("R4", {7'd0, scan_out}, {7'd0, q[W-1]});
    rst = 0;

    // R2 sweep all data values
    for (int v = 0; v < 256; v++) begin
      load(W'(v));
      check("R2", q, W'(v));
      check("R4", {7'd0, scan_out}, {7'd0, q[W-1]});
    end

    // R3 shift with d toggling, checks scan_out order
    load(8'h3C);
    m = 8'h3C;
    mode = 2'b00;
    for (int k = 0; k < 8; k++) begin
      check("R4", {7'd0, scan_out}, {7'd0, m[W-1]});
      scan_in = k[0] ^ k[2];
      d = ~d;
      m = {m[W-2:0], scan_in};
      tick();
      check("R3", q, m);
    end

    // R9 shift zeros clears
    load(8'hFF);
    mode = 2'b00; scan_in = 0;
    for (int k = 0; k < W; k++) begin d = 8'hFF; tick(); end
    check("R9", q, '0);

    // R6 zero lock in generate mode
    mode = 2'b01;
    for (int k = 0; k < 10; k++) begin d = 8'h5A + 8'(k); tick(); end
    check("R6", q, '0);

    // R5 full period from seed 1, d ignored
    seed = 8'h01;
    load(seed);
    m = seed; period = 0;
    mode = 2'b01;
    for (int k = 1; k <= 255; k++) begin
      d = 8'(k * 37);
      tick();
      m = step(m);
      check("R5", q, m);
      if (q == '0) check("R6", q, 8'h01);
      if (period == 0 && q == seed) period = k;
    end
    check("R5 period", 8'(period), 8'd255);

    // R7 exhaustive single step over states
    for (int v = 0; v < 256; v++) begin
      load(W'(v));
      mode = 2'b11; d = 8'(v * 13 + 7);
      tick();
      check("R7", q, step(W'(v)) ^ 8'(v * 13 + 7));
    end

    // R8 superposition over 20-cycle sequence
    for (int t = 0; t < 20; t++) seq[t] = 8'(t * 29 + 3) ^ 8'(t << 3);
    for (int l = 0; l < W; l++) begin
      acc = '0;
      for (int t = 0; t < 20; t++) acc = step(acc) ^ (seq[t] & (8'h01 << l));
      lane[l] = acc;
    end
    sig = '0;
    for (int l = 0; l < W; l++) sig = sig ^ lane[l];
    load('0);
    mode = 2'b11;
    for (int t = 0; t < 20; t++) begin d = seq[t]; tick(); end
    check("R8", q, sig);

    // R1 reset mid-run
    rst = 1; tick(); rst = 0;
    check("R1", q, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule